// File: doc/BRIEF.md
# Reset and Clear Sequencer

This block orders the start-up and recovery events of a multichannel converter register bank. It emits one-cycle initialization strobes to the bank. After a power-on reset, or a falling edge on the external reset pin, the bank is told to return gain registers to full scale, offset registers to zero scale and output data registers to zero. A falling edge on the external clear pin instead tells the bank to copy its user-programmed clear value into every output data register. The block only sequences these operations. The register bank itself and all analog behaviour sit outside it.

While any sequence runs, the `idle` output is low. In that time the host write path is disabled and update requests are blocked. Both pins pass through a two-flop synchronizer before falling-edge detection. A reset edge that arrives during a clear cuts the clear short and starts a full reset. A clear edge that arrives during a reset is dropped. The level of the queue-enable pin is latched as the operating mode only when a sequence completes. Sequence lengths are cycle-count parameters.

States: `ST_POR` (power-on sequence), `ST_RST` (pin reset sequence), `ST_CLR` (clear sequence), `ST_IDLE` (normal operation). Transitions:
- POR_DONE: POR to IDLE.
- RST_DONE: RST to IDLE.
- CLR_DONE: CLR to IDLE.
- RST_START: IDLE to RST.
- CLR_START: IDLE to CLR.
- CLR_ABORT: CLR to RST.

Top module: `rst_clr_seq`

## Requirements
- R1: When `por_n` is released, `idle` stays low for exactly RST_CYC cycles, starting with the cycle of release. `gain_def_stb`, `offs_def_stb` and `dac_zero_stb` are each high together in exactly the first of those cycles. While `por_n` is low, `idle` and `host_en` are low and `queue_mode` is 0.
- R2: A falling edge on `ext_rst_n` seen in `ST_IDLE` starts a reset sequence. During it `idle` is low for exactly RST_CYC cycles, the three default strobes pulse together once in its first cycle, and `dac_clr_stb` stays low.
- R3: When a reset sequence completes with `ext_rst_n` still held low, no new sequence starts. Only a new falling edge starts one.
- R4: A falling edge on `ext_clear_n` seen in `ST_IDLE` starts a clear sequence. During it `idle` is low for exactly CLR_CYC cycles, `dac_clr_stb` pulses once in its first cycle, and the default strobes stay low.
- R5: While `idle` is low, `host_en` and `upd_pass` are low whatever `upd_n` does. While idle, `host_en` is high and `upd_pass` equals the inverse of `upd_n`.
- R6: A falling edge on `ext_clear_n` during a reset sequence is ignored. The reset ends after its normal RST_CYC cycles and no `dac_clr_stb` pulse appears.
- R7: A falling edge on `ext_rst_n` during a clear sequence aborts the clear and starts a full reset. `idle` then stays low for RST_CYC cycles counted from the first reset cycle, and the default strobes pulse once.
- R8: `queue_mode` takes the synchronized level of `queue_en` when a power-on, reset or clear sequence completes. It holds that value through later changes of `queue_en` while idle.
- R9: The first sequence cycle, the first cycle with `idle` low, is the third clock edge after a pin falls. This accounts for two synchronizer flops and one edge-detection register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| ext_rst_n | input | 1 | External reset pin, falling-edge triggered |
| ext_clear_n | input | 1 | External clear pin, falling-edge triggered |
| queue_en | input | 1 | Queue enable pin, sampled at sequence completion |
| upd_n | input | 1 | Output update request, active low |
| idle | output | 1 | High when no sequence is running |
| host_en | output | 1 | Host write interface enable |
| upd_pass | output | 1 | Update request forwarded to the bank |
| gain_def_stb | output | 1 | Load gain registers with full scale |
| offs_def_stb | output | 1 | Load offset registers with zero scale |
| dac_zero_stb | output | 1 | Clear output data registers to zero |
| dac_clr_stb | output | 1 | Copy clear register into output data registers |
| queue_mode | output | 1 | Latched queue enable mode |

## Verification
The assertions check the following on every cycle:
- a reset sequence is entered only from a detected reset edge, and runs without interruption to its final count;
- a clear is entered only from idle on a clear edge, and its counter stays within its length;
- an abort from clear lands on the first reset cycle;
- the latched mode is steady while idle;
- updates are never forwarded while busy.

Some behaviours only the bench scenarios can show:
- exact sequence lengths and the three-edge pin latency;
- strobe counts per sequence;
- that a held-low reset pin does not retrigger.

The bench sweeps every cycle offset at which a competing edge can land inside a reset or a clear.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
    typedef enum logic [1:0] {
        ST_POR  = 2'd0,
        ST_RST  = 2'd1,
        ST_CLR  = 2'd2,
        ST_IDLE = 2'd3
    } seq_state_e;
endpackage

// File: rtl/rcs_sync.sv
module rcs_sync #(
    parameter int W = 1,
    parameter logic [W-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= INIT;
            q    <= INIT;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/rcs_fall_det.sv
module rcs_fall_det #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] fall
);
    logic [W-1:0] prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= '1;
        else        prev <= lvl;
    end

    for (genvar i = 0; i < W; i++) begin : g_edge
        assign fall[i] = prev[i] & ~lvl[i];
    end
endmodule

// File: rtl/rcs_seq_fsm.sv
module rcs_seq_fsm
    import rcs_pkg::*;
#(
    parameter int RST_CYC = 270,
    parameter int CLR_CYC = 35
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rst_fall,
    input  logic clr_fall,
    input  logic queue_en_s,
    output logic idle,
    output logic host_en,
    output logic gain_def_stb,
    output logic offs_def_stb,
    output logic dac_zero_stb,
    output logic dac_clr_stb,
    output logic queue_mode
);
    localparam int MAXC  = (RST_CYC > CLR_CYC) ? RST_CYC : CLR_CYC;
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam logic [CNT_W-1:0] RST_LAST = CNT_W'(RST_CYC - 1);
    localparam logic [CNT_W-1:0] CLR_LAST = CNT_W'(CLR_CYC - 1);

    seq_state_e       state, nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;
    logic             mode_ld;

    // next state
    always_comb begin
        nxt     = state;
        cnt_nxt = cnt + 1'b1;
        mode_ld = 1'b0;
        unique case (state)
            ST_POR, ST_RST: begin
                if (cnt == RST_LAST) begin
                    nxt     = ST_IDLE;
                    cnt_nxt = '0;
                    mode_ld = 1'b1;
                end
            end
            ST_CLR: begin
                if (rst_fall) begin
                    nxt     = ST_RST;
                    cnt_nxt = '0;
                end else if (cnt == CLR_LAST) begin
                    nxt     = ST_IDLE;
                    cnt_nxt = '0;
                    mode_ld = 1'b1;
                end
            end
            ST_IDLE: begin
                cnt_nxt = '0;
                if (rst_fall)      nxt = ST_RST;
                else if (clr_fall) nxt = ST_CLR;
            end
            default: begin
                nxt     = ST_IDLE;
                cnt_nxt = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_POR;
            cnt        <= '0;
            queue_mode <= 1'b0;
        end else begin
            state <= nxt;
            cnt   <= cnt_nxt;
            if (mode_ld) queue_mode <= queue_en_s;
        end
    end

    // outputs
    always_comb begin
        idle         = 1'b0;
        host_en      = 1'b0;
        gain_def_stb = 1'b0;
        offs_def_stb = 1'b0;
        dac_zero_stb = 1'b0;
        dac_clr_stb  = 1'b0;
        unique case (state)
            ST_POR, ST_RST: begin
                gain_def_stb = (cnt == '0);
                offs_def_stb = (cnt == '0);
                dac_zero_stb = (cnt == '0);
            end
            ST_CLR: dac_clr_stb = (cnt == '0);
            ST_IDLE: begin
                idle    = 1'b1;
                host_en = 1'b1;
            end
            default: idle = 1'b0;
        endcase
    end

    AST_RST_FROM_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RST && $past(state) != ST_RST) |-> $past(rst_fall)); // R2
    AST_RST_RUNS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RST && cnt != RST_LAST) |=> (state == ST_RST)); // R6
    AST_CLR_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CLR && $past(state) != ST_CLR) |-> ($past(clr_fall) && $past(state) == ST_IDLE)); // R4
    AST_CLR_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CLR) |-> (cnt <= CLR_LAST)); // R4
    AST_CLR_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CLR && rst_fall) |=> (state == ST_RST && cnt == '0)); // R7
    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && $past(state) == ST_IDLE) |-> $stable(queue_mode)); // R8
endmodule

// File: rtl/rst_clr_seq.sv
module rst_clr_seq #(
    parameter int RST_CYC = 270,
    parameter int CLR_CYC = 35
) (
    input  logic clk,
    input  logic por_n,
    input  logic ext_rst_n,
    input  logic ext_clear_n,
    input  logic queue_en,
    input  logic upd_n,
    output logic idle,
    output logic host_en,
    output logic upd_pass,
    output logic gain_def_stb,
    output logic offs_def_stb,
    output logic dac_zero_stb,
    output logic dac_clr_stb,
    output logic queue_mode
);
    localparam int NPIN = 3;

    logic [NPIN-1:0] pin_s;
    logic [1:0]      falls;

    rcs_sync #(.W(NPIN), .INIT(3'b011)) u_sync (
        .clk  (clk),
        .rst_n(por_n),
        .d    ({queue_en, ext_clear_n, ext_rst_n}),
        .q    (pin_s)
    );

    rcs_fall_det #(.W(2)) u_fall (
        .clk  (clk),
        .rst_n(por_n),
        .lvl  (pin_s[1:0]),
        .fall (falls)
    );

    rcs_seq_fsm #(.RST_CYC(RST_CYC), .CLR_CYC(CLR_CYC)) u_fsm (
        .clk         (clk),
        .rst_n       (por_n),
        .rst_fall    (falls[0]),
        .clr_fall    (falls[1]),
        .queue_en_s  (pin_s[2]),
        .idle        (idle),
        .host_en     (host_en),
        .gain_def_stb(gain_def_stb),
        .offs_def_stb(offs_def_stb),
        .dac_zero_stb(dac_zero_stb),
        .dac_clr_stb (dac_clr_stb),
        .queue_mode  (queue_mode)
    );

    assign upd_pass = host_en & ~upd_n;

    AST_UPD_BLOCKED: assert property (@(posedge clk) disable iff (!por_n)
        (!idle) |-> (!upd_pass && !host_en)); // R5
endmodule

// File: tb/tb_rst_clr_seq.sv
`timescale 1ns/1ps
module tb_rst_clr_seq;
    localparam int RC = 16;
    localparam int CC = 6;

    logic clk = 1'b0;
    logic por_n, ext_rst_n, ext_clear_n, queue_en, upd_n;
    logic idle, host_en, upd_pass, gain_def_stb, offs_def_stb, dac_zero_stb, dac_clr_stb, queue_mode;
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    rst_clr_seq #(.RST_CYC(RC), .CLR_CYC(CC)) dut (
        .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .ext_clear_n(ext_clear_n),
        .queue_en(queue_en), .upd_n(upd_n), .idle(idle), .host_en(host_en),
        .upd_pass(upd_pass), .gain_def_stb(gain_def_stb), .offs_def_stb(offs_def_stb),
        .dac_zero_stb(dac_zero_stb), .dac_clr_stb(dac_clr_stb), .queue_mode(queue_mode)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Counts one busy window starting at the current negedge.
    // inj_at >= 0 drops the other pin at that observation index.
    task automatic window(input int inj_at, input bit inj_rst,
                          output int nb, output int ng, output int nc, output int bad);
        int idx = 0;
        nb = 0; ng = 0; nc = 0; bad = 0;
        while (idle == 1'b0 && idx < 2000) begin
            nb++;
            ng += int'(gain_def_stb);
            nc += int'(dac_clr_stb);
            if (gain_def_stb != offs_def_stb || gain_def_stb != dac_zero_stb) bad++;
            if (host_en || upd_pass) bad++;
            if (idx == inj_at) begin
                if (inj_rst) ext_rst_n = 1'b0;
                else         ext_clear_n = 1'b0;
            end
            idx++;
            @(negedge clk);
        end
    endtask

    task automatic trigger(input bit use_rst, input string req);
        if (use_rst) ext_rst_n = 1'b0;
        else         ext_clear_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(idle == 1'b1, "R9", "idle before third edge", int'(idle), 1);
        @(negedge clk);
        chk(idle == 1'b0, req, "sequence started at third edge", int'(idle), 0);
    endtask

    task automatic release_pins();
        ext_rst_n = 1'b1;
        ext_clear_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        int nb, ng, nc, bad, held;
        por_n = 1'b0; ext_rst_n = 1'b1; ext_clear_n = 1'b1; queue_en = 1'b1; upd_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(idle == 1'b0 && host_en == 1'b0, "R1", "idle/host_en in reset", int'({idle, host_en}), 0);
        chk(queue_mode == 1'b0, "R1", "queue_mode in reset", int'(queue_mode), 0);
        por_n = 1'b1;
        window(-1, 1'b0, nb, ng, nc, bad);
        chk(nb == RC, "R1", "power-on busy length", nb, RC);
        chk(ng == 1, "R1", "power-on default strobes", ng, 1);
        chk(bad == 0, "R5", "blocked/strobe mismatch during power-on", bad, 0);
        chk(queue_mode == 1'b1, "R8", "mode after power-on", int'(queue_mode), 1);

        // R5: update forwarding while idle
        upd_n = 1'b0; #1;
        chk(upd_pass == 1'b1 && host_en == 1'b1, "R5", "pass while idle, upd_n=0", int'(upd_pass), 1);
        upd_n = 1'b1; #1;
        chk(upd_pass == 1'b0, "R5", "pass while idle, upd_n=1", int'(upd_pass), 0);
        @(negedge clk);
        upd_n = 1'b0;

        // R2, R3, R8: pin reset with both mode values
        for (int f = 0; f < 2; f++) begin
            queue_en = f[0];
            trigger(1'b1, "R2");
            window(-1, 1'b0, nb, ng, nc, bad);
            chk(nb == RC, "R2", "reset busy length", nb, RC);
            chk(ng == 1 && nc == 0, "R2", "reset strobe counts (g*10+c)", ng * 10 + nc, 10);
            chk(bad == 0, "R5", "blocked/strobe mismatch during reset", bad, 0);
            chk(queue_mode == f[0], "R8", "mode after reset", int'(queue_mode), f);
            held = 0;
            for (int i = 0; i < 20; i++) begin
                if (idle != 1'b1) held++;
                @(negedge clk);
            end
            chk(held == 0, "R3", "held-low reset retriggered (busy cycles)", held, 0);
            queue_en = ~f[0];
            repeat (10) @(negedge clk);
            chk(queue_mode == f[0], "R8", "mode held while idle", int'(queue_mode), f);
            release_pins();
        end

        // R4: clear
        queue_en = 1'b1;
        trigger(1'b0, "R4");
        window(-1, 1'b0, nb, ng, nc, bad);
        chk(nb == CC, "R4", "clear busy length", nb, CC);
        chk(ng == 0 && nc == 1, "R4", "clear strobe counts (g*10+c)", ng * 10 + nc, 1);
        chk(queue_mode == 1'b1, "R8", "mode after clear", int'(queue_mode), 1);
        release_pins();

        // R6: clear edge at every offset inside a reset
        for (int k = 0; k <= RC - 3; k++) begin
            trigger(1'b1, "R2");
            window(k, 1'b0, nb, ng, nc, bad);
            chk(nb == RC, "R6", $sformatf("reset length with clear at %0d", k), nb, RC);
            chk(nc == 0 && ng == 1, "R6", "strobes with clear ignored (g*10+c)", ng * 10 + nc, 10);
            repeat (3) @(negedge clk);
            chk(idle == 1'b1, "R6", "no late clear after reset", int'(idle), 1);
            release_pins();
        end

        // R7: reset edge at every offset inside a clear
        for (int k = 0; k <= CC - 3; k++) begin
            trigger(1'b0, "R4");
            window(k, 1'b1, nb, ng, nc, bad);
            chk(nb == k + 3 + RC, "R7", $sformatf("busy length with reset at %0d", k), nb, k + 3 + RC);
            chk(ng == 1 && nc == 1, "R7", "strobes on abort (g*10+c)", ng * 10 + nc, 11);
            chk(bad == 0, "R5", "blocked/strobe mismatch during abort", bad, 0);
            release_pins();
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule